// File: doc/BRIEF.md
# Single-Wire RGB LED Pulse Encoder

This block turns a stream of colour bytes into the self-clocked, one-wire waveform that daisy-chained addressable RGB LEDs read. A producer hands it one byte at a time over a valid/ready handshake, and flags the final byte of a frame. Each data bit becomes one pulse of fixed period. The line rises at the start of the period, and the width of the high part alone tells the LED whether the bit is a 0 or a 1.

Bytes leave most significant bit first, in the order they were accepted. For an LED string the producer sends three bytes per pixel: green, then red, then blue. A one-byte holding register lets the next byte be taken while the current one is still on the wire, so consecutive bytes follow each other with no added gap. After the final byte the line is held low for a latch interval, which makes the LEDs take up the new colours.

The cycle counts for the high times, the bit period and the latch interval are all computed at elaboration from the clock frequency parameter. Each count is rounded to the nearest cycle.

Top module: `led_pulse_encoder`

## Requirements
- R1: After reset the line is low, `busy` is low, `gap_err` is low and `in_ready` is high.
- R2: Accepted bytes appear on the line in acceptance order, most significant bit first, one pulse per bit.
- R3: A 0 bit is high for round(T0H_NS·CLK_HZ/1e9) cycles, which is 7 at 20 MHz. A 1 bit is high for round(T1H_NS·CLK_HZ/1e9) cycles, which is 14 at 20 MHz. The line is low for the rest of the bit period.
- R4: Rising edges of consecutive bits are exactly round(BIT_NS·CLK_HZ/1e9) cycles apart (25 at 20 MHz). This also holds across byte boundaries when the next byte was accepted before the current byte ended.
- R5: After the final bit of a byte marked last, the line stays low for at least round(LATCH_NS·CLK_HZ/1e9) cycles (1100 cycles, 55 µs at 20 MHz) before `busy` falls. `in_ready` is low during this interval.
- R6: If a byte not marked last finishes and no next byte is available, the line idles low and `gap_err` goes high. The next accepted byte resumes transmission and clears `gap_err`.
- R7: `busy` is high from the first accepted byte until the latch interval ends. `in_ready` is low while the holding register is full, and low after a byte marked last has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Colour byte |
| in_last | input | 1 | Byte is the last of the frame |
| in_ready | output | 1 | Block can take a byte this cycle |
| led_out | output | 1 | Registered serial line to the LEDs |
| busy | output | 1 | Frame in progress, including the latch interval |
| gap_err | output | 1 | Stream stalled inside a frame; line idling low |

## Verification
The hardest situation to reach from the ports is a stall inside a frame: the final bit of a byte ends with neither a byte in the holding register nor one offered. The bench produces it by offering a byte that is not marked last and then withholding the next byte for several bit periods. It then checks that the line stays low while `gap_err` is high, and that a decoded byte boundary follows correctly after the resume. The full-range sweep sends all 256 byte values in one frame. Each byte is offered during the previous byte's transmission, so every byte boundary goes through the holding register, and the bench times every pulse against the arithmetic period.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_GAP   = 2'd2,
    ST_LATCH = 2'd3
  } lpe_state_e;

  // nanoseconds to clock cycles, rounded to nearest
  function automatic int unsigned cyc_of_ns(longint unsigned ns, longint unsigned hz);
    longint unsigned num;
    num = ns * hz + 64'd500_000_000;
    return 32'(num / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/lpe_bit_wave.sv
module lpe_bit_wave #(
  parameter int unsigned PER = 25,
  parameter int unsigned T0H = 7,
  parameter int unsigned T1H = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_val,
  output logic line_d,
  output logic bit_end
);
  localparam int unsigned CW = $clog2(PER);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!run)                    cnt <= '0;
    else if (cnt == CW'(PER - 1))     cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign bit_end = run && (cnt == CW'(PER - 1));
  assign line_d  = run && (cnt < (bit_val ? CW'(T1H) : CW'(T0H)));
endmodule

// File: rtl/lpe_span_counter.sv
module lpe_span_counter #(
  parameter int unsigned LIMIT = 1100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!run || done)            cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/lpe_hold_reg.sv
module lpe_hold_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] d_data,
  input  logic          d_last,
  output logic          full,
  output logic [DW-1:0] q_data,
  output logic          q_last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      q_data <= '0;
      q_last <= 1'b0;
    end else if (push) begin
      full   <= 1'b1;
      q_data <= d_data;
      q_last <= d_last;
    end else if (pop) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/led_pulse_encoder.sv
module led_pulse_encoder
  import lpe_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 20_000_000,
  parameter int unsigned     DW       = 8,
  parameter int unsigned     T0H_NS   = 350,
  parameter int unsigned     T1H_NS   = 700,
  parameter int unsigned     BIT_NS   = 1250,
  parameter int unsigned     LATCH_NS = 55_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          led_out,
  output logic          busy,
  output logic          gap_err
);
  localparam int unsigned T0H_CYC   = cyc_of_ns(T0H_NS, CLK_HZ);
  localparam int unsigned T1H_CYC   = cyc_of_ns(T1H_NS, CLK_HZ);
  localparam int unsigned PER_CYC   = cyc_of_ns(BIT_NS, CLK_HZ);
  localparam int unsigned LATCH_CYC = cyc_of_ns(LATCH_NS, CLK_HZ);
  localparam int unsigned IW        = $clog2(DW);

  lpe_state_e    st;
  logic [DW-1:0] shreg;
  logic [IW-1:0] bit_idx;
  logic          cur_last;

  // named internal events, used by the bound checker
  logic ev_accept, ev_bit_end, ev_byte_end, ev_latch_active, ev_latch_done;
  logic line_d, hold_full, hold_last, push, pop;
  logic [DW-1:0] hold_data;

  assign ev_accept       = in_valid && in_ready;
  assign ev_byte_end     = ev_bit_end && (bit_idx == '0);
  assign ev_latch_active = (st == ST_LATCH);

  assign in_ready = (st == ST_IDLE) || (st == ST_GAP) ||
                    ((st == ST_SEND) && !hold_full && !cur_last);
  assign push     = ev_accept && (st == ST_SEND) && !ev_byte_end;
  assign pop      = (st == ST_SEND) && ev_byte_end && hold_full;

  lpe_bit_wave #(.PER(PER_CYC), .T0H(T0H_CYC), .T1H(T1H_CYC)) u_wave (
    .clk(clk), .rst_n(rst_n), .run(st == ST_SEND), .bit_val(shreg[DW-1]),
    .line_d(line_d), .bit_end(ev_bit_end)
  );

  lpe_span_counter #(.LIMIT(LATCH_CYC)) u_latch (
    .clk(clk), .rst_n(rst_n), .run(ev_latch_active), .done(ev_latch_done)
  );

  lpe_hold_reg #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .d_data(in_data), .d_last(in_last),
    .full(hold_full), .q_data(hold_data), .q_last(hold_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      shreg    <= '0;
      bit_idx  <= '0;
      cur_last <= 1'b0;
      led_out  <= 1'b0;
    end else begin
      led_out <= line_d;
      unique case (st)
        ST_IDLE, ST_GAP: begin
          if (ev_accept) begin
            shreg    <= in_data;
            cur_last <= in_last;
            bit_idx  <= IW'(DW - 1);
            st       <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (ev_bit_end) begin
            if (bit_idx != '0) begin
              shreg   <= shreg << 1;
              bit_idx <= bit_idx - 1'b1;
            end else if (hold_full) begin
              shreg    <= hold_data;
              cur_last <= hold_last;
              bit_idx  <= IW'(DW - 1);
            end else if (ev_accept) begin
              shreg    <= in_data;
              cur_last <= in_last;
              bit_idx  <= IW'(DW - 1);
            end else if (cur_last) begin
              cur_last <= 1'b0;
              st       <= ST_LATCH;
            end else begin
              st       <= ST_GAP;
            end
          end
        end
        ST_LATCH: begin
          if (ev_latch_done) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign gap_err = (st == ST_GAP);
endmodule

// File: rtl/lpe_checks.sv
module lpe_checks
  import lpe_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 20_000_000,
  parameter int unsigned     T0H_NS   = 350,
  parameter int unsigned     T1H_NS   = 700,
  parameter int unsigned     BIT_NS   = 1250,
  parameter int unsigned     LATCH_NS = 55_000
) (
  input logic clk,
  input logic rst_n,
  input logic led_out,
  input logic busy,
  input logic gap_err,
  input logic in_ready,
  input logic ev_latch_active
);
  localparam int unsigned T0H_C   = cyc_of_ns(T0H_NS, CLK_HZ);
  localparam int unsigned T1H_C   = cyc_of_ns(T1H_NS, CLK_HZ);
  localparam int unsigned PER_C   = cyc_of_ns(BIT_NS, CLK_HZ);
  localparam int unsigned LATCH_C = cyc_of_ns(LATCH_NS, CLK_HZ);

  logic [15:0] hi_run, lo_run, since_rise;
  logic        led_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run     <= '0;
      lo_run     <= '0;
      since_rise <= 16'(PER_C);
      led_prev   <= 1'b0;
    end else begin
      led_prev <= led_out;
      hi_run   <= led_out ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      lo_run   <= led_out ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
      if (led_out && !led_prev)      since_rise <= 16'd1;
      else if (since_rise != 16'hFFFF) since_rise <= since_rise + 1'b1;
    end
  end

  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!led_out && led_prev) |-> (hi_run == 16'(T0H_C) || hi_run == 16'(T1H_C))); // R3
  AST_RISE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (led_out && !led_prev) |-> (since_rise >= 16'(PER_C))); // R4
  AST_GAP_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |-> !led_out); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!led_out && in_ready && !gap_err)); // R1
  AST_LATCH_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch_active |-> !in_ready); // R5
  AST_BUSY_END_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> ($past(ev_latch_active) && $past(lo_run) >= 16'(LATCH_C - 1))); // R5
endmodule

bind led_pulse_encoder lpe_checks #(
  .CLK_HZ(CLK_HZ), .T0H_NS(T0H_NS), .T1H_NS(T1H_NS),
  .BIT_NS(BIT_NS), .LATCH_NS(LATCH_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .led_out(led_out), .busy(busy),
  .gap_err(gap_err), .in_ready(in_ready), .ev_latch_active(ev_latch_active)
);

// File: tb/sim_led_pulse_encoder.sv
module sim_led_pulse_encoder;
  localparam int CLK_P   = 10;
  localparam int CLK_MHZ = 20;
  localparam int T0H_B   = (350 * CLK_MHZ + 500) / 1000;
  localparam int T1H_B   = (700 * CLK_MHZ + 500) / 1000;
  localparam int PER_B   = (1250 * CLK_MHZ + 500) / 1000;
  localparam int LATCH_B = (55000 * CLK_MHZ + 500) / 1000;
  localparam int MIN_LOW = 50 * CLK_MHZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, led_out, busy, gap_err;

  int n_chk = 0, n_bad = 0, n_rx = 0, n_tx = 0;
  logic [7:0] expq[$];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  led_pulse_encoder #(.CLK_HZ(64'd20_000_000)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .led_out(led_out),
    .busy(busy), .gap_err(gap_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // line monitor: rebuilds bytes from pulse widths
  int  hi_run = 0, lo_run = 0, since_rise = 1000, nbits = 0;
  logic [7:0] acc = '0;
  logic prev_led = 0, prev_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (led_out && !prev_led) begin
        if (since_rise < 3 * PER_B) chk(since_rise == PER_B, "R4 bit spacing", since_rise, PER_B);
        since_rise = 0;
      end
      if (!led_out && prev_led) begin
        chk(hi_run == T0H_B || hi_run == T1H_B, "R3 high width", hi_run, T0H_B);
        acc = {acc[6:0], (hi_run == T1H_B)};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          n_rx++;
          if (expq.size() == 0) chk(0, "R2 unexpected byte", acc, -1);
          else begin
            logic [7:0] e;
            e = expq.pop_front();
            chk(acc == e, "R2 byte value", acc, e);
          end
        end
      end
      if (led_out) begin hi_run++; lo_run = 0; end
      else begin hi_run = 0; lo_run++; end
      if (busy && !gap_err && !led_out && lo_run == PER_B + 5)
        chk(in_ready == 0, "R5 ready low in latch", in_ready, 0);
      if (prev_busy && !busy) begin
        chk(lo_run >= LATCH_B, "R5 latch length", lo_run, LATCH_B);
        chk(lo_run >= MIN_LOW, "R5 latch 50us", lo_run, MIN_LOW);
      end
      prev_led = led_out;
      prev_busy = busy;
    end
  end

  task automatic push(input logic [7:0] b, input logic l);
    bit rd;
    in_valid = 1'b1; in_data = b; in_last = l;
    expq.push_back(b); n_tx++;
    forever begin
      rd = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (rd) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100000 && busy; i++) @(negedge clk);
    chk(busy == 0, "R7 busy clears", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(led_out == 0, "R1 line low", led_out, 0);
    chk(busy == 0, "R1 busy low", busy, 0);
    chk(gap_err == 0, "R1 gap_err low", gap_err, 0);
    chk(in_ready == 1, "R1 ready high", in_ready, 1);

    // short frame, hold register fills
    push(8'hA5, 0);
    chk(busy == 1, "R7 busy after accept", busy, 1);
    push(8'h00, 0);
    chk(in_ready == 0, "R7 ready low when hold full", in_ready, 0);
    push(8'hFF, 1);
    chk(in_ready == 0, "R7 ready low after last", in_ready, 0);
    wait_idle();

    // full byte sweep in one frame
    for (int v = 0; v < 256; v++) push(8'(v), v == 255);
    wait_idle();

    // stall inside a frame
    push(8'h3C, 0);
    for (int i = 0; i < 2000 && !gap_err; i++) @(negedge clk);
    chk(gap_err == 1, "R6 gap_err raised", gap_err, 1);
    repeat (4 * PER_B) begin
      @(negedge clk);
      if (led_out != 0 || gap_err != 1) chk(0, "R6 line low in gap", led_out, 0);
    end
    chk(busy == 1, "R7 busy during gap", busy, 1);
    push(8'hC3, 1);
    chk(gap_err == 0, "R6 gap_err cleared", gap_err, 1'b0);
    wait_idle();

    // single-byte frame
    push(8'h81, 1);
    wait_idle();
    repeat (5) @(negedge clk);
    chk(led_out == 0, "R1 line idles low", led_out, 0);
    chk(expq.size() == 0, "R2 all bytes seen", expq.size(), 0);
    chk(n_rx == n_tx, "R2 byte count", n_rx, n_tx);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule